// File: doc/BRIEF.md
# Interleaved Memory Window Address Router

This block sits behind one fixed host memory window and steers every request that lands in it towards a downstream device. A request carries an offset relative to the window. The block adds the window base to get a host physical address. A first interleave stage then picks a host bridge from the window's list of ways. A second stage is a committed device decoder, which picks an 8-bit downstream port number from a packed target list.

Requests that resolve to a port leave on the forward interface. The forward interface carries the host physical address, the bridge index and the port number. Requests that resolve to nothing are completed inside the block. A read that misses comes back as zero data with an error flag. A write that misses is dropped and acknowledged as successful.

The window and decoder settings are static configuration inputs. Each route is registered in a single output slot with valid/ready flow control.

Top module: `imw_router`

## Requirements
- R1: A forwarded request carries `fwd_addr` = `cfg_win_base` + `req_addr`, truncated to the address width. The write flag, the size and the write data (little-endian byte lanes) pass through unchanged.
- R2: The bridge index `fwd_hb` is (host address >> (8 + `cfg_win_gran`)) modulo `cfg_win_ways`. Granularity code 0 selects 256-byte interleave, and code g selects 256 << g bytes.
- R3: `cfg_err` is high when any of these holds: `cfg_win_size` is zero, bits 27:0 of `cfg_win_size` are not zero, `cfg_win_gran` is 7, `cfg_win_ways` is 0, or `cfg_win_ways` is above MAX_HB. While `cfg_err` is high, every request misses.
- R4: The decoder takes part only when bit 8 of `cfg_dec_ctrl` (committed) is 1. Otherwise every request misses.
- R5: The decoder index is (host address >> (8 + ctrl[3:0])) modulo 2^ctrl[7:4]. Entries 0..3 come from `cfg_dec_list_lo` and entries 4..7 from `cfg_dec_list_hi`, at bit offset (index mod 4)×8. That byte is `fwd_port`. A ctrl[3:0] above 6 or a ctrl[7:4] above 3 makes the request miss.
- R6: A read that misses raises `cpl_valid` with `cpl_err` = 1 and `cpl_rdata` = 0, and raises no `fwd_valid`.
- R7: A write that misses raises `cpl_valid` with `cpl_err` = 0, and raises no `fwd_valid`.
- R8: A request with `req_addr` >= `cfg_win_size` misses.
- R9: Sizes 1 to 8 bytes are routed at any byte alignment. A `req_size` of 0 or above 8 misses.
- R10: A request is accepted in the cycle where `req_valid` and `req_ready` are both high. Its result appears on the outputs one cycle later. `req_ready` is high when the slot is empty or is being drained. A stalled output holds its values.
- R11: During reset and after reset, `fwd_valid` and `cpl_valid` are low until a request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_win_base | input | ADDR_W | Host address of window offset 0 |
| cfg_win_size | input | ADDR_W | Window size in bytes |
| cfg_win_gran | input | 3 | Window granularity code |
| cfg_win_ways | input | CNT_W | Number of host bridges in the window |
| cfg_dec_ctrl | input | 9 | Decoder control: [3:0] granularity, [7:4] ways code, [8] committed |
| cfg_dec_list_lo | input | 32 | Decoder port numbers for entries 0..3 |
| cfg_dec_list_hi | input | 32 | Decoder port numbers for entries 4..7 |
| cfg_err | output | 1 | Window configuration rejected |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Window-relative byte address |
| req_size | input | 4 | Access size in bytes |
| req_wdata | input | DATA_W | Write data, little-endian |
| fwd_valid | output | 1 | Routed request present |
| fwd_ready | input | 1 | Downstream takes the routed request |
| fwd_write | output | 1 | Write flag of routed request |
| fwd_addr | output | ADDR_W | Host physical address |
| fwd_size | output | 4 | Access size |
| fwd_wdata | output | DATA_W | Write data |
| fwd_hb | output | HB_W | Selected host bridge index |
| fwd_port | output | 8 | Selected downstream port number |
| cpl_valid | output | 1 | Local completion present |
| cpl_ready | input | 1 | Requester takes the local completion |
| cpl_write | output | 1 | Completion belongs to a write |
| cpl_err | output | 1 | Error response (read miss) |
| cpl_rdata | output | DATA_W | Read data of a local completion (zero) |

## Verification
The bench sweeps every window way count from 1 to 8 against several window and decoder granularities and every decoder ways code. It uses a base that is not aligned to a granule, so a design that interleaved on the offset rather than on the host address would pick the wrong bridge. A design that decoded granularity off by one would also pick the wrong bridge, and so would one that took a non-power-of-two modulo wrongly. Directed cases cover the following:
- an uncommitted decoder, where a design that ignored the commit bit would forward;
- the read/write asymmetry on a miss, where a swapped error flag or non-zero data shows;
- offsets at and past the window end;
- sizes 0, 1, 8 and 9;
- each configuration rejection;
- out-of-range decoder codes;
- a stalled output that must neither change nor accept a new request.

// File: rtl/imw_pkg.sv
package imw_pkg;
  localparam int unsigned GRAN_SHIFT_BASE  = 8;
  localparam int unsigned GRAN_ENC_MAX     = 6;
  localparam int unsigned WIN_ALIGN_BITS   = 28;
  localparam int unsigned DEC_WAYS_ENC_MAX = 3;
  localparam int unsigned DEC_IDX_W        = 3;
  localparam int unsigned CTRL_W           = 9;
  localparam int unsigned CTRL_GRAN_LSB    = 0;
  localparam int unsigned CTRL_WAYS_LSB    = 4;
  localparam int unsigned CTRL_COMMIT_BIT  = 8;
  localparam int unsigned ACC_MIN_BYTES    = 1;
  localparam int unsigned ACC_MAX_BYTES    = 8;
  localparam int unsigned SIZE_W           = 4;

  typedef logic [7:0] port_id_t;

  typedef enum logic [1:0] {
    SLOT_EMPTY = 2'd0,
    SLOT_FWD   = 2'd1,
    SLOT_LOCAL = 2'd2
  } slot_kind_t;
endpackage

// File: rtl/imw_modn.sv
module imw_modn #(
  parameter int unsigned W  = 40,
  parameter int unsigned DW = 4
) (
  input  logic [W-1:0]  value,
  input  logic [DW-1:0] divisor,
  output logic [DW-1:0] rem
);
  // Bit-serial restoring remainder, one stage per dividend bit.
  logic [DW-1:0] part [0:W];
  assign part[0] = '0;

  for (genvar gi = 0; gi < W; gi++) begin : g_stage
    logic [DW:0] trial;
    assign trial = {part[gi], value[W-1-gi]};
    assign part[gi+1] = DW'((trial >= {1'b0, divisor}) ? (trial - {1'b0, divisor}) : trial);
  end

  assign rem = part[W];
endmodule

// File: rtl/imw_window_stage.sv
module imw_window_stage
  import imw_pkg::*;
#(
  parameter int unsigned ADDR_W = 40,
  parameter int unsigned CNT_W  = 4,
  parameter int unsigned HB_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] req_off,
  input  logic [ADDR_W-1:0] win_base,
  input  logic [ADDR_W-1:0] win_size,
  input  logic [2:0]        win_gran,
  input  logic [CNT_W-1:0]  win_ways,
  input  logic              cfg_ok,
  output logic [ADDR_W-1:0] hpa,
  output logic              in_range,
  output logic [HB_W-1:0]   hb_idx
);
  logic [3:0]        gran_shift;
  logic [ADDR_W-1:0] granule;
  logic [CNT_W-1:0]  way_rem;

  assign hpa        = win_base + req_off;
  assign in_range   = (req_off < win_size);
  assign gran_shift = 4'(GRAN_SHIFT_BASE) + {1'b0, win_gran};
  assign granule    = hpa >> gran_shift;

  imw_modn #(.W(ADDR_W), .DW(CNT_W)) u_way_mod (
    .value   (granule),
    .divisor (win_ways),
    .rem     (way_rem)
  );

  assign hb_idx = way_rem[HB_W-1:0];

  // R2
  hb_in_list_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_ok |-> (way_rem < win_ways));
endmodule

// File: rtl/imw_hdm_stage.sv
module imw_hdm_stage
  import imw_pkg::*;
#(
  parameter int unsigned ADDR_W = 40
) (
  input  logic [ADDR_W-1:0] hpa,
  input  logic [CTRL_W-1:0] ctrl,
  input  logic [31:0]       list_lo,
  input  logic [31:0]       list_hi,
  output logic              hit,
  output port_id_t          port
);
  logic [3:0]           gran_enc;
  logic [3:0]           ways_enc;
  logic                 committed;
  logic                 codes_ok;
  logic [3:0]           idx_shift;
  logic [DEC_IDX_W-1:0] raw_idx;
  logic [DEC_IDX_W-1:0] way_mask;
  logic [DEC_IDX_W-1:0] entry;
  logic [63:0]          list_all;

  assign gran_enc  = ctrl[CTRL_GRAN_LSB +: 4];
  assign ways_enc  = ctrl[CTRL_WAYS_LSB +: 4];
  assign committed = ctrl[CTRL_COMMIT_BIT];
  assign codes_ok  = (gran_enc <= 4'(GRAN_ENC_MAX)) && (ways_enc <= 4'(DEC_WAYS_ENC_MAX));

  assign idx_shift = 4'(GRAN_SHIFT_BASE) + {1'b0, gran_enc[2:0]};
  assign raw_idx   = hpa[idx_shift +: DEC_IDX_W];
  assign way_mask  = DEC_IDX_W'((4'd1 << ways_enc[1:0]) - 4'd1);
  assign entry     = raw_idx & way_mask;

  assign list_all  = {list_hi, list_lo};
  assign port      = list_all[{entry, 3'b000} +: 8];
  assign hit       = committed && codes_ok;
endmodule

// File: rtl/imw_router.sv
module imw_router
  import imw_pkg::*;
#(
  parameter int unsigned ADDR_W = 40,
  parameter int unsigned DATA_W = 64,
  parameter int unsigned MAX_HB = 8,
  localparam int unsigned CNT_W = $clog2(MAX_HB + 1),
  localparam int unsigned HB_W  = $clog2(MAX_HB)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cfg_win_base,
  input  logic [ADDR_W-1:0] cfg_win_size,
  input  logic [2:0]        cfg_win_gran,
  input  logic [CNT_W-1:0]  cfg_win_ways,
  input  logic [8:0]        cfg_dec_ctrl,
  input  logic [31:0]       cfg_dec_list_lo,
  input  logic [31:0]       cfg_dec_list_hi,
  output logic              cfg_err,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [3:0]        req_size,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              fwd_valid,
  input  logic              fwd_ready,
  output logic              fwd_write,
  output logic [ADDR_W-1:0] fwd_addr,
  output logic [3:0]        fwd_size,
  output logic [DATA_W-1:0] fwd_wdata,
  output logic [HB_W-1:0]   fwd_hb,
  output logic [7:0]        fwd_port,
  output logic              cpl_valid,
  input  logic              cpl_ready,
  output logic              cpl_write,
  output logic              cpl_err,
  output logic [DATA_W-1:0] cpl_rdata
);
  // Reset: asynchronous assertion, synchronous release.
  logic rst_q1, rst_q2, rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q1 <= 1'b0;
      rst_q2 <= 1'b0;
    end else begin
      rst_q1 <= 1'b1;
      rst_q2 <= rst_q1;
    end
  end
  assign rst_i = rst_q2;

  // Configuration check.
  logic win_cfg_bad;
  assign win_cfg_bad = (cfg_win_size == '0)
                    || (cfg_win_size[WIN_ALIGN_BITS-1:0] != '0)
                    || (cfg_win_gran > 3'(GRAN_ENC_MAX))
                    || (cfg_win_ways == '0)
                    || (cfg_win_ways > CNT_W'(MAX_HB));
  assign cfg_err = win_cfg_bad;

  // Stage one: window to host bridge.
  logic [ADDR_W-1:0] hpa;
  logic              in_range;
  logic [HB_W-1:0]   hb_idx;

  imw_window_stage #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .HB_W(HB_W)) u_win (
    .clk      (clk),
    .rst_n    (rst_i),
    .req_off  (req_addr),
    .win_base (cfg_win_base),
    .win_size (cfg_win_size),
    .win_gran (cfg_win_gran),
    .win_ways (cfg_win_ways),
    .cfg_ok   (!win_cfg_bad),
    .hpa      (hpa),
    .in_range (in_range),
    .hb_idx   (hb_idx)
  );

  // Stage two: committed decoder to port.
  logic     dec_hit;
  port_id_t dec_port;

  imw_hdm_stage #(.ADDR_W(ADDR_W)) u_dec (
    .hpa     (hpa),
    .ctrl    (cfg_dec_ctrl),
    .list_lo (cfg_dec_list_lo),
    .list_hi (cfg_dec_list_hi),
    .hit     (dec_hit),
    .port    (dec_port)
  );

  logic size_ok, route_hit;
  assign size_ok   = (req_size >= SIZE_W'(ACC_MIN_BYTES)) && (req_size <= SIZE_W'(ACC_MAX_BYTES));
  assign route_hit = !win_cfg_bad && in_range && dec_hit && size_ok;

  // Output slot.
  slot_kind_t        slot_q, slot_d;
  logic              wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [3:0]        size_q;
  logic [DATA_W-1:0] wdata_q;
  logic [HB_W-1:0]   hb_q;
  port_id_t          port_q;
  logic              accept, drain, load_en;

  assign drain     = (fwd_valid && fwd_ready) || (cpl_valid && cpl_ready);
  assign req_ready = (slot_q == SLOT_EMPTY) || drain;
  assign accept    = req_valid && req_ready;
  assign load_en   = accept;

  always_comb begin
    slot_d = slot_q;
    if (accept)     slot_d = route_hit ? SLOT_FWD : SLOT_LOCAL;
    else if (drain) slot_d = SLOT_EMPTY;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) slot_q <= SLOT_EMPTY;
    else        slot_q <= slot_d;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      wr_q    <= 1'b0;
      addr_q  <= '0;
      size_q  <= '0;
      wdata_q <= '0;
      hb_q    <= '0;
      port_q  <= '0;
    end else if (load_en) begin
      wr_q    <= req_write;
      addr_q  <= hpa;
      size_q  <= req_size;
      wdata_q <= req_wdata;
      hb_q    <= hb_idx;
      port_q  <= dec_port;
    end
  end

  assign fwd_valid = (slot_q == SLOT_FWD);
  assign fwd_write = wr_q;
  assign fwd_addr  = addr_q;
  assign fwd_size  = size_q;
  assign fwd_wdata = wdata_q;
  assign fwd_hb    = hb_q;
  assign fwd_port  = port_q;

  assign cpl_valid = (slot_q == SLOT_LOCAL);
  assign cpl_write = wr_q;
  assign cpl_err   = cpl_valid && !wr_q;
  assign cpl_rdata = '0;

  // R3
  cfg_reject_miss_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (accept && win_cfg_bad) |=> (cpl_valid && !fwd_valid));

  // R4
  uncommitted_miss_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (accept && !cfg_dec_ctrl[CTRL_COMMIT_BIT]) |=> cpl_valid);

  // R6
  read_miss_poison_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (accept && !req_write && !route_hit) |=> (cpl_valid && cpl_err && (cpl_rdata == '0)));

  // R7
  write_miss_silent_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (accept && req_write && !route_hit) |=> (cpl_valid && !cpl_err && !fwd_valid));

  // R10
  fwd_stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (fwd_valid && !fwd_ready) |=> (fwd_valid && $stable(fwd_addr) && $stable(fwd_port) && $stable(fwd_hb)));

  // R10
  cpl_stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (cpl_valid && !cpl_ready) |=> (cpl_valid && $stable(cpl_err)));
endmodule

// File: tb/imw_router_test.sv
module imw_router_test;
  localparam int ADDR_W = 40;
  localparam int DATA_W = 64;
  localparam int MAX_HB = 8;
  localparam int CNT_W  = 4;
  localparam int HB_W   = 3;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [ADDR_W-1:0] cfg_win_base, cfg_win_size;
  logic [2:0]        cfg_win_gran;
  logic [CNT_W-1:0]  cfg_win_ways;
  logic [8:0]        cfg_dec_ctrl;
  logic [31:0]       cfg_dec_list_lo, cfg_dec_list_hi;
  logic              cfg_err;
  logic              req_valid, req_ready, req_write;
  logic [ADDR_W-1:0] req_addr;
  logic [3:0]        req_size;
  logic [DATA_W-1:0] req_wdata;
  logic              fwd_valid, fwd_ready, fwd_write;
  logic [ADDR_W-1:0] fwd_addr;
  logic [3:0]        fwd_size;
  logic [DATA_W-1:0] fwd_wdata;
  logic [HB_W-1:0]   fwd_hb;
  logic [7:0]        fwd_port;
  logic              cpl_valid, cpl_ready, cpl_write, cpl_err;
  logic [DATA_W-1:0] cpl_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  imw_router #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAX_HB(MAX_HB)) uut (
    .clk(clk), .rst_n(rst_n),
    .cfg_win_base(cfg_win_base), .cfg_win_size(cfg_win_size),
    .cfg_win_gran(cfg_win_gran), .cfg_win_ways(cfg_win_ways),
    .cfg_dec_ctrl(cfg_dec_ctrl), .cfg_dec_list_lo(cfg_dec_list_lo),
    .cfg_dec_list_hi(cfg_dec_list_hi), .cfg_err(cfg_err),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .fwd_valid(fwd_valid), .fwd_ready(fwd_ready), .fwd_write(fwd_write),
    .fwd_addr(fwd_addr), .fwd_size(fwd_size), .fwd_wdata(fwd_wdata),
    .fwd_hb(fwd_hb), .fwd_port(fwd_port),
    .cpl_valid(cpl_valid), .cpl_ready(cpl_ready), .cpl_write(cpl_write),
    .cpl_err(cpl_err), .cpl_rdata(cpl_rdata)
  );

  task automatic check(input bit ok, input string req, input string msg,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, msg, act, exp);
    end
  endtask

  task automatic send(input bit wr, input logic [ADDR_W-1:0] a,
                      input logic [3:0] sz, input logic [DATA_W-1:0] wd);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz; req_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  function automatic logic [7:0] exp_port(input longint unsigned hpa, input int ig, input int iw);
    longint unsigned idx;
    logic [31:0] reg_sel;
    idx = (hpa / (longint'(256) << ig)) % (longint'(1) << iw);
    reg_sel = (idx < 4) ? cfg_dec_list_lo : cfg_dec_list_hi;
    return 8'((reg_sel >> ((idx % 4) * 8)) & 32'hFF);
  endfunction

  task automatic expect_miss(input bit wr, input string req, input string msg);
    check(cpl_valid && !fwd_valid, req, {msg, " local completion"}, {cpl_valid, fwd_valid}, 2'b10);
    if (wr) check(!cpl_err, req, {msg, " write ok"}, cpl_err, 0);
    else    check(cpl_err && cpl_rdata == 0, req, {msg, " read poison"}, cpl_rdata, 0);
  endtask

  task automatic good_cfg();
    cfg_win_base = 40'h00_3000_0140;
    cfg_win_size = 40'h00_2000_0000;
    cfg_win_gran = 3'd0;
    cfg_win_ways = 4'd3;
    cfg_dec_ctrl = 9'h1_00;
    cfg_dec_list_lo = 32'h44332211;
    cfg_dec_list_hi = 32'h88776655;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 0; req_write = 0; req_addr = 0; req_size = 1; req_wdata = 0;
    fwd_ready = 1; cpl_ready = 1;
    good_cfg();
    repeat (3) @(negedge clk);
    // R11: reset state
    check(!fwd_valid && !cpl_valid, "R11", "outputs in reset", {fwd_valid, cpl_valid}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!fwd_valid && !cpl_valid && req_ready, "R11", "idle after reset", {fwd_valid, cpl_valid, req_ready}, 1);
    check(!cfg_err, "R3", "valid config accepted", cfg_err, 0);

    // R1 R2 R5 R9: sweep
    for (int n = 1; n <= 8; n++)
      for (int g = 0; g <= 2; g++)
        for (int iw = 0; iw <= 3; iw++)
          for (int ig = 0; ig <= 2; ig++)
            for (int k = 0; k < 12; k++) begin
              longint unsigned off, hpa;
              logic [3:0] sz;
              bit wr;
              cfg_win_ways = 4'(n);
              cfg_win_gran = 3'(g);
              cfg_dec_ctrl = {1'b1, 4'(iw), 4'(ig)};
              off = longint'(k) * 64'h9D71 + longint'(n * 7);
              hpa = 64'(cfg_win_base) + off;
              sz = 4'((k % 8) + 1);
              wr = k[0];
              send(wr, ADDR_W'(off), sz, {32'(k), 32'(n * 100 + g)});
              check(fwd_valid && !cpl_valid, "R1", "routed", {fwd_valid, cpl_valid}, 2'b10);
              check(fwd_addr == ADDR_W'(hpa) && fwd_write == wr && fwd_size == sz &&
                    fwd_wdata == {32'(k), 32'(n * 100 + g)}, "R1", "address/payload", fwd_addr, hpa);
              check(64'(fwd_hb) == (hpa / (longint'(256) << g)) % longint'(n), "R2", "bridge index",
                    fwd_hb, (hpa / (longint'(256) << g)) % longint'(n));
              check(fwd_port == exp_port(hpa, ig, iw), "R5", "port", fwd_port, exp_port(hpa, ig, iw));
            end

    good_cfg();
    // R9: size edges
    send(0, 40'h105, 4'd1, 0);
    check(fwd_valid, "R9", "size 1 unaligned", fwd_valid, 1);
    send(1, 40'h3, 4'd8, 64'h0102030405060708);
    check(fwd_valid && fwd_wdata == 64'h0102030405060708, "R9", "size 8 unaligned", fwd_wdata, 64'h0102030405060708);
    send(0, 40'h10, 4'd0, 0);
    expect_miss(0, "R9", "size 0");
    send(1, 40'h10, 4'd9, 0);
    expect_miss(1, "R9", "size 9");

    // R8: window end
    send(0, 40'h00_1FFF_FFFF, 4'd1, 0);
    check(fwd_valid, "R8", "last byte", fwd_valid, 1);
    send(0, 40'h00_2000_0000, 4'd1, 0);
    expect_miss(0, "R8", "at size");
    send(1, 40'h00_2000_0040, 4'd4, 0);
    expect_miss(1, "R8", "past size");

    // R4 R6 R7: uncommitted decoder
    cfg_dec_ctrl = 9'h0_00;
    send(0, 40'h200, 4'd4, 0);
    expect_miss(0, "R6", "uncommitted read");
    send(1, 40'h200, 4'd4, 64'hFFFF);
    expect_miss(1, "R7", "uncommitted write");
    check(cpl_write, "R4", "completion flags write", cpl_write, 1);

    // R5: bad decoder codes
    cfg_dec_ctrl = {1'b1, 4'd4, 4'd0};
    send(0, 40'h200, 4'd4, 0);
    expect_miss(0, "R5", "ways code 4");
    cfg_dec_ctrl = {1'b1, 4'd1, 4'd7};
    send(1, 40'h200, 4'd4, 0);
    expect_miss(1, "R5", "granularity code 7");
    good_cfg();

    // R3: configuration rejection
    cfg_win_size = 40'h00_1000_1000;
    #1 check(cfg_err, "R3", "misaligned size", cfg_err, 1);
    send(0, 40'h10, 4'd1, 0);
    expect_miss(0, "R3", "request under bad size");
    good_cfg(); cfg_win_size = 0;
    #1 check(cfg_err, "R3", "zero size", cfg_err, 1);
    good_cfg(); cfg_win_gran = 3'd7;
    #1 check(cfg_err, "R3", "granularity 7", cfg_err, 1);
    send(1, 40'h10, 4'd1, 0);
    expect_miss(1, "R3", "request under bad granularity");
    good_cfg(); cfg_win_ways = 0;
    #1 check(cfg_err, "R3", "zero ways", cfg_err, 1);
    good_cfg(); cfg_win_ways = 4'd9;
    #1 check(cfg_err, "R3", "nine ways", cfg_err, 1);
    good_cfg(); cfg_win_ways = 4'd8;
    #1 check(!cfg_err, "R3", "eight ways", cfg_err, 0);
    good_cfg();

    // R10: backpressure
    fwd_ready = 0;
    send(0, 40'h400, 4'd2, 0);
    check(fwd_valid && fwd_addr == 40'h00_3000_0540, "R10", "stalled A", fwd_addr, 40'h00_3000_0540);
    req_valid = 1; req_write = 0; req_addr = 40'h800; req_size = 4'd2;
    #1 check(!req_ready, "R10", "not ready while stalled", req_ready, 0);
    @(posedge clk); @(negedge clk);
    check(fwd_valid && fwd_addr == 40'h00_3000_0540, "R10", "A held", fwd_addr, 40'h00_3000_0540);
    fwd_ready = 1;
    #1 check(req_ready, "R10", "ready on drain", req_ready, 1);
    @(posedge clk); @(negedge clk);
    req_valid = 0;
    check(fwd_valid && fwd_addr == 40'h00_3000_0940, "R10", "B after drain", fwd_addr, 40'h00_3000_0940);
    @(posedge clk); @(negedge clk);
    check(!fwd_valid && !cpl_valid, "R10", "slot empties", {fwd_valid, cpl_valid}, 0);

    // R10: stalled local completion
    cpl_ready = 0;
    cfg_dec_ctrl = 9'h0_00;
    send(0, 40'h10, 4'd1, 0);
    @(posedge clk); @(negedge clk);
    check(cpl_valid && cpl_err && !req_ready, "R10", "completion held", {cpl_valid, cpl_err, req_ready}, 3'b110);
    cpl_ready = 1;
    @(posedge clk); @(negedge clk);
    check(!cpl_valid, "R10", "completion drained", cpl_valid, 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule